// File: doc/BRIEF.md
# Prescaled Gated Pulse-Count Converter

This block measures how many pulses a fast pulse train delivers during a timed window, which gives a frequency reading or, behind a voltage-to-frequency front end, an integrating conversion. The count lives in two counters. A narrow prescaler is clocked directly by the pulse input, so it keeps up with rates above the system clock. A wider slow counter runs on the system clock. It samples the prescaler's top bit through a synchroniser and advances once each time that bit wraps from one to zero. The combined word has the slow counter above the prescaler bits.

A sequencer runs each conversion after a `start` request. It keeps the gate closed long enough for the counters to settle and, in difference mode, takes a first snapshot. It then opens the gate for the requested number of clock cycles, closes it, waits for the counters to settle again and takes a second snapshot. The result is the second snapshot minus the first, modulo the word width. The counters are never cleared between conversions, so a wrap during a window is handled by the modular subtraction.

In clear mode, chosen by a parameter, the sequencer instead holds an internal clear during the settle phase. The final snapshot is then the result and no subtraction is needed. The prescaler width is derived from the ratio between the fastest input rate and the rate the slow counter can follow, so slower inputs use fewer prescaler bits.

Top module: `gated_count_conv`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `gate` and `done` are 0 and `result` is 0.
- R2: `period` is sampled with `start`, and `gate` is then high for exactly that many clock cycles. A period of 0 never opens the gate and yields a result of 0.
- R3: `done` is high for a single cycle, exactly 2*SETTLE+PERIOD cycles after the clock edge that accepts `start`, where SETTLE = SYNC_STAGES+2. `result` changes only on that edge and holds until the next `done`.
- R4: In difference mode (CLEAR_MODE=0), `result` equals the number of rising edges of `pulse_in` that arrive while `gate` is high, modulo 2^WORD_W. This holds when the running counters wrap inside the window.
- R5: The prescaler is $clog2(RATE_RATIO) bits wide and forms the low bits of the word, with the SLOW_W-bit slow counter above it. The slow counter advances by at most one per clock, on each 1-to-0 wrap of the prescaler top bit. Pulse rates above the clock rate are counted exactly, provided each level of that top bit lasts at least two clocks.
- R6: Each snapshot is taken SETTLE cycles after the gate was last low-going or idle, with `gate` low, so the word is not changing when it is captured.
- R7: In clear mode (CLEAR_MODE=1), an internal clear is held for the SETTLE cycles before the window opens. It zeroes the prescaler and the slow counter, and `result` equals the count in the window with the same timing as R3.
- R8: A `start` that arrives while a conversion is in progress is ignored: there is no second `done` and the window length is unchanged.
- R9: Pulses that arrive while `gate` is low do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Pulse train to be counted; clocks the prescaler |
| start | input | 1 | Conversion request, sampled while idle |
| period | input | PERIOD_W | Window length in clock cycles |
| gate | output | 1 | High while the counters are allowed to advance |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | $clog2(RATE_RATIO)+SLOW_W | Pulse count of the last window |

## Verification
Taking the clock edge that accepts `start` as cycle 0, the window opens at cycle SETTLE and closes at SETTLE+PERIOD. `done` rises at 2*SETTLE+PERIOD. The bench drives `start` on a falling edge and counts falling edges until `done` is seen, so the latency is measured exactly. It compares the result on that same falling edge against its own count of pulse edges seen while `gate` was high. Pulse edges are placed at fractional nanoseconds, so they never coincide with a clock edge and the reference count is unambiguous. The cycle after `done`, and again after a wait longer than a full conversion, the bench checks that `done` has dropped and that `result` has held.

// File: rtl/gcc_pkg.sv
`timescale 1ns/100ps
package gcc_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PRE  = 2'd1,
      SEQ_OPEN = 2'd2,
      SEQ_POST = 2'd3
   } seq_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // prescaler bits needed to absorb a given fast/slow rate ratio
   function automatic int pre_bits(input int ratio);
      return $clog2(ratio);
   endfunction

endpackage

// File: rtl/gcc_prescaler.sv
`timescale 1ns/100ps
module gcc_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic             pulse_in,
   input  logic             arst_n,
   input  logic             gate,
   output logic [PRE_W-1:0] count
);

   // fast counter in the pulse domain; holds while the gate is low
   always_ff @(posedge pulse_in or negedge arst_n) begin
      if (!arst_n) begin
         count <= '0;
      end else if (gate) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/gcc_slow_count.sv
`timescale 1ns/100ps
module gcc_slow_count #(
   parameter int PRE_W       = 4,
   parameter int SLOW_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W     = PRE_W + SLOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [PRE_W-1:0]  pre_raw,
   output logic [WORD_W-1:0] word
);

   logic [PRE_W-1:0]  stage_q [SYNC_STAGES];
   logic [SLOW_W-1:0] slow_q;
   logic              msb_prev_q;
   logic              msb_now;
   logic              wrap;

   // synchroniser for the whole prescaler bus; only the top bit is
   // used while counting, the rest is read once the gate has settled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) begin
            stage_q[s] <= '0;
         end
      end else begin
         stage_q[0] <= pre_raw;
         for (int s = 1; s < SYNC_STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign msb_now = stage_q[SYNC_STAGES-1][PRE_W-1];
   assign wrap    = msb_prev_q & ~msb_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slow_q     <= '0;
         msb_prev_q <= 1'b0;
      end else if (clr) begin
         slow_q     <= '0;
         msb_prev_q <= msb_now;
      end else begin
         slow_q     <= slow_q + SLOW_W'(wrap);
         msb_prev_q <= msb_now;
      end
   end

   assign word = {slow_q, stage_q[SYNC_STAGES-1]};

endmodule

// File: rtl/gcc_sequencer.sv
`timescale 1ns/100ps
module gcc_sequencer
   import gcc_pkg::*;
#(
   parameter int PERIOD_W   = 24,
   parameter int WORD_W     = 20,
   parameter int SETTLE     = 4,
   parameter int CLEAR_MODE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PERIOD_W-1:0] period,
   input  logic [WORD_W-1:0]   word,
   output logic                gate,
   output logic                clr,
   output logic                cap,
   output logic                done,
   output logic [WORD_W-1:0]   result
);

   localparam int CNT_W = max_int(PERIOD_W, $clog2(SETTLE + 1));

   seq_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [PERIOD_W-1:0] period_q;
   logic                gate_q;
   logic                done_q;
   logic [WORD_W-1:0]   result_q;
   logic [WORD_W-1:0]   conv_val;
   logic                pre_end;
   logic                accept;

   assign accept  = (state_q == SEQ_IDLE) && start;
   assign pre_end = (state_q == SEQ_PRE)  && (cnt_q == '0);
   assign cap     = (state_q == SEQ_POST) && (cnt_q == '0);

   generate
      if (CLEAR_MODE == 0) begin : g_diff
         logic [WORD_W-1:0] x1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               x1_q <= '0;
            end else if (pre_end) begin
               x1_q <= word;
            end
         end
         assign conv_val = word - x1_q;
         assign clr      = 1'b0;
      end else begin : g_clear
         logic clr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clr_q <= 1'b0;
            end else if (accept) begin
               clr_q <= 1'b1;
            end else if (pre_end) begin
               clr_q <= 1'b0;
            end
         end
         assign conv_val = word;
         assign clr      = clr_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         cnt_q    <= '0;
         period_q <= '0;
         gate_q   <= 1'b0;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q  <= SEQ_PRE;
                  cnt_q    <= CNT_W'(SETTLE - 1);
                  period_q <= period;
               end
            end
            SEQ_PRE: begin
               if (cnt_q == '0) begin
                  if (period_q != '0) begin
                     state_q <= SEQ_OPEN;
                     cnt_q   <= CNT_W'(period_q - 1'b1);
                     gate_q  <= 1'b1;
                  end else begin
                     state_q <= SEQ_POST;
                     cnt_q   <= CNT_W'(SETTLE - 1);
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_OPEN: begin
               if (cnt_q == '0) begin
                  state_q <= SEQ_POST;
                  cnt_q   <= CNT_W'(SETTLE - 1);
                  gate_q  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_POST: begin
               if (cnt_q == '0) begin
                  state_q  <= SEQ_IDLE;
                  result_q <= conv_val;
                  done_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign gate   = gate_q;
   assign done   = done_q;
   assign result = result_q;

endmodule

// File: rtl/gated_count_conv.sv
`timescale 1ns/100ps
module gated_count_conv #(
   parameter int RATE_RATIO  = 16,
   parameter int SLOW_W      = 16,
   parameter int PERIOD_W    = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CLEAR_MODE  = 0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                pulse_in,
   input  logic                                start,
   input  logic [PERIOD_W-1:0]                 period,
   output logic                                gate,
   output logic                                done,
   output logic [SLOW_W+$clog2(RATE_RATIO)-1:0] result
);

   localparam int PRE_W  = gcc_pkg::pre_bits(RATE_RATIO);
   localparam int WORD_W = PRE_W + SLOW_W;
   localparam int SETTLE = SYNC_STAGES + 2;

   generate
      if (RATE_RATIO < 2 || RATE_RATIO > 256) begin : g_bad_ratio
         $error("RATE_RATIO must lie in 2..256");
      end
      if (SLOW_W < 2) begin : g_bad_slow
         $error("SLOW_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CLEAR_MODE != 0 && CLEAR_MODE != 1) begin : g_bad_mode
         $error("CLEAR_MODE must be 0 or 1");
      end
      if (PERIOD_W < 1) begin : g_bad_period
         $error("PERIOD_W must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_cnt;
   logic [WORD_W-1:0] word;
   logic              clr;
   logic              cap;
   logic              pre_arst_n;

   assign pre_arst_n = rst_n & ~clr;

   gcc_prescaler #(
      .PRE_W (PRE_W)
   ) u_pre (
      .pulse_in (pulse_in),
      .arst_n   (pre_arst_n),
      .gate     (gate),
      .count    (pre_cnt)
   );

   gcc_slow_count #(
      .PRE_W       (PRE_W),
      .SLOW_W      (SLOW_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_slow (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .pre_raw (pre_cnt),
      .word    (word)
   );

   gcc_sequencer #(
      .PERIOD_W   (PERIOD_W),
      .WORD_W     (WORD_W),
      .SETTLE     (SETTLE),
      .CLEAR_MODE (CLEAR_MODE)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .period (period),
      .word   (word),
      .gate   (gate),
      .clr    (clr),
      .cap    (cap),
      .done   (done),
      .result (result)
   );

endmodule

// File: rtl/gated_count_conv_chk.sv
`timescale 1ns/100ps
module gated_count_conv_chk #(
   parameter int WORD_W = 20,
   parameter int PRE_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gate,
   input logic              done,
   input logic              clr,
   input logic              cap,
   input logic [WORD_W-1:0] word,
   input logic [WORD_W-1:0] result
);

   localparam int SLOW_W = WORD_W - PRE_W;

   logic [SLOW_W-1:0] slow;
   assign slow = word[WORD_W-1:PRE_W];

   // R3: done lasts one cycle
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: result only moves together with done
   a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R2: the window is closed whenever a result is reported
   a_r2_gate_closed_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !gate);

   // R5: slow counter never steps by more than one
   a_r5_slow_step: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (slow == $past(slow)) || (slow == SLOW_W'($past(slow) + 1'b1)));

   // R6: word is quiet and the gate low at each snapshot
   a_r6_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> (!gate && $stable(word)));

   // R7: clear and open window never overlap
   a_r7_clear_excl: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !gate);

endmodule

bind gated_count_conv gated_count_conv_chk #(
   .WORD_W (WORD_W),
   .PRE_W  (PRE_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .gate   (gate),
   .done   (done),
   .clr    (clr),
   .cap    (cap),
   .word   (word),
   .result (result)
);

// File: tb/gated_count_conv_test.sv
`timescale 1ns/100ps
module gated_count_conv_test;

   localparam int SETTLE = 4;
   localparam int WA     = 12;  // 4 prescaler bits + 8 slow bits
   localparam int WB     = 11;  // 3 prescaler bits + 8 slow bits

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse_in = 1'b0;
   logic          start = 1'b0;
   logic [11:0]   period = '0;
   logic          gate_a, done_a, gate_b, done_b;
   logic [WA-1:0] res_a;
   logic [WB-1:0] res_b;

   int      n_checks = 0;
   int      n_fail = 0;
   realtime half_ns = 1.5;
   bit      pulse_en = 1'b0;
   int unsigned gated_a = 0, gated_b = 0, gate_hi_a = 0;
   int unsigned done_cnt_a = 0, done_cnt_b = 0;

   gated_count_conv #(
      .RATE_RATIO(16), .SLOW_W(8), .PERIOD_W(12), .SYNC_STAGES(2), .CLEAR_MODE(0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .start(start),
      .period(period), .gate(gate_a), .done(done_a), .result(res_a)
   );

   gated_count_conv #(
      .RATE_RATIO(8), .SLOW_W(8), .PERIOD_W(12), .SYNC_STAGES(2), .CLEAR_MODE(1)
   ) uut_clr (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .start(start),
      .period(period), .gate(gate_b), .done(done_b), .result(res_b)
   );

   always #2 clk = ~clk;

   // pulse edges sit on .1/.6 ns, never on a clock edge
   initial begin
      #0.1;
      forever begin
         if (pulse_en) begin
            pulse_in = 1'b1;
            #(half_ns);
            pulse_in = 1'b0;
            #(half_ns);
         end else begin
            #1;
         end
      end
   end

   always @(posedge pulse_in) begin
      if (gate_a) gated_a++;
      if (gate_b) gated_b++;
   end

   always @(negedge clk) begin
      if (gate_a) gate_hi_a++;
      if (done_a) done_cnt_a++;
      if (done_b) done_cnt_b++;
   end

   task automatic check_eq(input string req, input string what,
                           input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_conv(input int p, input realtime half, input bit extra_start);
      int unsigned a0, b0, g0, da0, db0;
      int lat;
      logic [WA-1:0] hold_a;
      logic [WB-1:0] hold_b;
      half_ns = half;
      pulse_en = 1'b1;
      @(negedge clk);
      a0 = gated_a; b0 = gated_b; g0 = gate_hi_a;
      da0 = done_cnt_a; db0 = done_cnt_b;
      period = 12'(p);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done_a && lat < p + 100) begin
         @(negedge clk);
         lat++;
         start = (extra_start && lat == 3);   // R8: request while busy
      end
      start = 1'b0;
      check_eq("R3", "done latency", lat, 2 * SETTLE + p);
      check_eq("R7", "clear-mode done aligned", done_b, 1);
      check_eq("R2", "gate high cycles", gate_hi_a - g0, p);
      check_eq("R6", "gate low at capture", gate_a, 0);
      check_eq("R4", "difference result", res_a, (gated_a - a0) % (1 << WA));
      check_eq("R7", "clear-mode result", res_b, (gated_b - b0) % (1 << WB));
      if (p * 4.0 > half * 2.0 * p && p > 100)   // pulses faster than clock
         check_eq("R5", "count above clock rate", res_a > p, 1);
      hold_a = res_a;
      hold_b = res_b;
      @(negedge clk);
      check_eq("R3", "done single cycle", done_a, 0);
      repeat (2 * SETTLE + p + 6) @(negedge clk);
      check_eq("R3", "result held", res_a, hold_a);
      check_eq("R3", "clear result held", res_b, hold_b);
      check_eq("R8", "one done per start", done_cnt_a - da0, 1);
      check_eq("R8", "one clear-mode done", done_cnt_b - db0, 1);
   endtask

   initial begin
      #1;
      repeat (3) @(negedge clk);
      check_eq("R1", "gate in reset", gate_a, 0);
      check_eq("R1", "done in reset", done_a, 0);
      check_eq("R1", "result in reset", res_a, 0);
      check_eq("R1", "clear result in reset", res_b, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", "gate after reset", gate_a | gate_b, 0);
      check_eq("R1", "done after reset", done_a | done_b, 0);

      run_conv(1000, 1.5, 1'b0);
      run_conv(1200, 2.0, 1'b0);
      run_conv(1500, 2.5, 1'b0);
      run_conv(1100, 1.5, 1'b0);   // difference-mode counters wrap (R4)
      // R9: pulses keep arriving with the gate shut, then a zero window
      repeat (200) @(negedge clk);
      run_conv(0, 1.5, 1'b0);
      check_eq("R9", "zero window ignores pulses", res_a, 0);
      check_eq("R2", "zero window clear result", res_b, 0);
      run_conv(1, 1.5, 1'b0);
      run_conv(2, 2.0, 1'b1);
      run_conv(700, 3.5, 1'b1);
      run_conv(1300, 1.5, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule